// File: doc/BRIEF.md
# Time-Division Slot-Table Memory Arbiter

This block decides which of a fixed set of bus clients may use one memory region in each arbitration cycle. The decision comes from a programmable table of slots, each slot holding a client number. A slot pointer walks the table one slot per clock. For each slot, the client named there is granted the memory if it is requesting. If that client is not requesting, or the slot holds no client, the slot stays empty. No other client may take it. Each client's share of the memory is therefore fixed by how many slots software gives it, whatever the other clients do.

Software loads the table one slot at a time through a plain write port: a strobe, a slot index and a client number. Loading may go on while arbitration runs. A chip with separate external and internal memory regions places one instance of this block per region, and each instance keeps its own table. The grant outputs are plain control pins with no handshake. A grant lasts exactly one clock and cannot be stalled, because the pointer never waits.

Top module: `tdm_slot_arbiter`

## Requirements
- R1: Reset (rst_n low, asynchronous) forces grant and grant_valid low, sets every table entry to unowned and sets the pointer to slot 0. After release, every slot gives no grant until it is written.
- R2: Counting the rising edges after reset release as n = 0, 1, 2, ..., the block evaluates slot n mod 64 at edge n, so the pointer wraps from slot 63 back to slot 0.
- R3: At the edge that evaluates a slot holding client c (0..13) while req[c] is high, grant has only bit c set and holds it until the next edge.
- R4: A slot whose 4-bit entry is 14 or 15 is unowned: the edge that evaluates it produces grant = 0, whatever the requests are.
- R5: At the edge that evaluates a slot holding client c while req[c] is low, grant = 0, even when other clients request.
- R6: grant has at most one bit set, and grant_valid is high exactly when grant is nonzero.
- R7: A write with wr_en high stores wr_client (4 bits) into the slot at wr_idx (6 bits), one slot per write. The new value is used the next time the pointer reaches that slot. A write to the slot being evaluated at that same edge does not change that edge's grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 6 | Slot index to write |
| wr_client | input | 4 | Client number to store (14 or 15 means unowned) |
| req | input | 14 | Per-client request lines |
| grant | output | 14 | One-hot grant, registered |
| grant_valid | output | 1 | High when a grant is issued this cycle |

## Verification
The hardest case to reach from the ports is a table write that lands on the same edge that evaluates the slot being written. The ports never show the pointer. The stimulus therefore counts edges since reset release to find the pointer position, and it writes slot 10 exactly when the pointer sits there. It then checks that the old owner still gets that pass and the new owner gets the next pass. The scoreboard model follows the table through live reprogramming, sparse request masks and a second reset.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;
  localparam int DEF_CLIENTS = 14;
  localparam int DEF_SLOTS   = 64;
  localparam int DEF_ENTRY_W = 4;
endpackage

// File: rtl/tdm_slot_store.sv
module tdm_slot_store #(
  parameter int SLOTS   = tdm_arb_pkg::DEF_SLOTS,
  parameter int ENTRY_W = tdm_arb_pkg::DEF_ENTRY_W,
  localparam int IDX_W  = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_data
);
  localparam logic [ENTRY_W-1:0] UNOWNED = '1;

  logic [ENTRY_W-1:0] entries [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) entries[s] <= UNOWNED;
    end else if (wr_en) begin
      entries[wr_idx] <= wr_data;
    end
  end

  assign rd_data = entries[rd_idx];

  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (entries[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/tdm_slot_pointer.sv
module tdm_slot_pointer #(
  parameter int SLOTS  = tdm_arb_pkg::DEF_SLOTS,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ptr <= '0;
    else if (ptr == LAST)  ptr <= '0;
    else                   ptr <= ptr + 1'b1;
  end

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));
  assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == LAST) |=> (ptr == '0));
  assert_ptr_home_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (ptr == '0));
endmodule

// File: rtl/tdm_grant_decode.sv
module tdm_grant_decode #(
  parameter int CLIENTS = tdm_arb_pkg::DEF_CLIENTS,
  parameter int ENTRY_W = tdm_arb_pkg::DEF_ENTRY_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRY_W-1:0] owner,
  input  logic [CLIENTS-1:0] req,
  output logic [CLIENTS-1:0] grant,
  output logic               grant_valid
);
  logic [CLIENTS-1:0] grant_d;

  for (genvar c = 0; c < CLIENTS; c++) begin : g_match
    assign grant_d[c] = (owner == ENTRY_W'(c)) && req[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant       <= '0;
      grant_valid <= 1'b0;
    end else begin
      grant       <= grant_d;
      grant_valid <= |grant_d;
    end
  end

  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((grant & ~$past(req)) == '0));
  assert_unowned_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (owner >= ENTRY_W'(CLIENTS)) |=> !grant_valid);
endmodule

// File: rtl/tdm_slot_arbiter.sv
module tdm_slot_arbiter #(
  parameter int CLIENTS = tdm_arb_pkg::DEF_CLIENTS,
  parameter int SLOTS   = tdm_arb_pkg::DEF_SLOTS,
  parameter int ENTRY_W = tdm_arb_pkg::DEF_ENTRY_W,
  localparam int IDX_W  = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_client,
  input  logic [CLIENTS-1:0] req,
  output logic [CLIENTS-1:0] grant,
  output logic               grant_valid
);
  logic [IDX_W-1:0]   ptr;
  logic [ENTRY_W-1:0] owner;

  tdm_slot_pointer #(.SLOTS(SLOTS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ptr(ptr)
  );

  tdm_slot_store #(.SLOTS(SLOTS), .ENTRY_W(ENTRY_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_client), .rd_idx(ptr), .rd_data(owner)
  );

  tdm_grant_decode #(.CLIENTS(CLIENTS), .ENTRY_W(ENTRY_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .owner(owner), .req(req),
    .grant(grant), .grant_valid(grant_valid)
  );

  assert_valid_tracks_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (grant != '0));
endmodule

// File: tb/tdm_slot_arbiter_test.sv
module tdm_slot_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [3:0]  wr_client = '0;
  logic [13:0] req = '0;
  logic [13:0] grant;
  logic        grant_valid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int ptr_m  = 0;
  logic [3:0] tbl_m [64];
  string phase = "R1";

  logic [13:0] exp_g [$];
  string       exp_tag [$];

  tdm_slot_arbiter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_client(wr_client), .req(req), .grant(grant), .grant_valid(grant_valid)
  );

  always #4 clk = ~clk;

  // Reference model: evaluates the slot at each edge, then applies the write.
  always @(posedge clk) begin
    logic [13:0] g;
    cycles++;
    g = '0;
    if (!rst_n) begin
      for (int s = 0; s < 64; s++) tbl_m[s] = 4'hF;
      ptr_m = 0;
      exp_g.push_back('0);
      exp_tag.push_back("R1");
    end else begin
      if (tbl_m[ptr_m] < 4'd14 && req[tbl_m[ptr_m]]) g[tbl_m[ptr_m]] = 1'b1;
      exp_g.push_back(g);
      exp_tag.push_back(phase);
      if (wr_en) tbl_m[wr_idx] = wr_client;
      ptr_m = (ptr_m + 1) % 64;
    end
  end

  // Monitor: compares at the falling edge.
  always @(negedge clk) begin
    if (exp_g.size() > 0) begin
      logic [13:0] e;
      string t;
      e = exp_g.pop_front();
      t = exp_tag.pop_front();
      checks++;
      if (grant !== e) begin
        fails++;
        $display("FAIL %s grant: actual %h expected %h", t, grant, e);
      end
      checks++;
      if (grant_valid !== (e != '0)) begin
        fails++;
        $display("FAIL R6 grant_valid: actual %b expected %b", grant_valid, (e != '0));
      end
    end
  end

  task automatic write_slot(input int idx, input int cl);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_client = 4'(cl);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    wait (cycles > 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finish_run();
  end

  initial begin
    // R1: reset state, then all slots unowned after release
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    req = '1;
    phase = "R4";
    repeat (70) @(negedge clk);
    // Program the table while arbitration runs (R7)
    phase = "R7";
    for (int i = 0; i < 64; i++)
      write_slot(i, (i < 56) ? (i % 14) : ((i % 2) ? 14 : 15));
    // R3: full requests grant every owned slot
    phase = "R3";
    repeat (130) @(negedge clk);
    // R5: sparse requests leave slots empty
    phase = "R5";
    req = 14'h1555; repeat (64) @(negedge clk);
    req = 14'h2AAA; repeat (64) @(negedge clk);
    req = '0;       repeat (20) @(negedge clk);
    req = '1;
    // R7: write the slot evaluated at this very edge
    phase = "R7";
    while (ptr_m != 10) @(negedge clk);
    write_slot(10, 3);
    write_slot(20, 15);
    repeat (130) @(negedge clk);
    // R2: wrap across several table passes
    phase = "R2";
    repeat (140) @(negedge clk);
    // R1: second reset clears the table
    rst_n = 1'b0;
    phase = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (70) @(negedge clk);
    finish_run();
  end
endmodule